// File: doc/BRIEF.md
# Upper Memory Window Access Router

This block sits between the processor's memory request path and the system's memory and bus agents. For every processor access it decides whether main memory answers it or the access is sent out on the PCI expansion bus. It also decides whether the second-level cache may keep the data. The decision covers the legacy upper memory window from C0000h to FFFFFh. Accesses outside that window always go to main memory.

The window is cut into sixteen 16 KB regions. Each region has a 4-bit attribute, and eight byte-wide registers hold them. Software loads these registers through a simple write port. A region can be disabled, read-only, write-only or read-write. Read and write accesses are routed separately, so software can copy a ROM that lives on the bus into memory at the same address. While the region is write-only, the read goes to the bus and the following write goes to memory. Afterwards the region is switched to read-only.

Each access presents an address, a write flag and a code-fetch flag. The block answers one clock later with a memory-select, a forward-to-bus strobe and a cacheable flag.

Top module: `upper_mem_router`

## Requirements
- R1: After reset all attribute registers are 00h and all three response outputs and `rsp_valid` are low. Until software writes the registers, every access inside the window is forwarded to the bus and is not cacheable.
- R2: An address inside the window selects region index `addr[17:14]`. Attribute register `addr[17:15]` holds it: bits 3:0 when `addr[14]` is 0, and bits 7:4 when `addr[14]` is 1.
- R3: Within an attribute nibble, bit 0 enables reads, bit 1 enables writes and bit 2 enables caching. Bit 3 has no effect on any output.
- R4: If both the read-enable and write-enable bits are 0, every access to the region is forwarded to the bus and is not cacheable.
- R5: If read-enable is 1 and write-enable is 0, reads go to memory and writes are forwarded. A read is cacheable only when cache-enable is 1 and the access is a code fetch.
- R6: If write-enable is 1 and read-enable is 0, writes go to memory and reads are forwarded. Both are non-cacheable, whatever cache-enable says.
- R7: If both enables are 1, reads and writes go to memory. They are cacheable exactly when cache-enable is 1.
- R8: An access below C0000h or above FFFFFh goes to memory and is cacheable, whatever the attribute registers hold.
- R9: The response for an access sampled at a clock edge appears after that edge, with `rsp_valid` high, and holds for one cycle. In a cycle without an access all response outputs are low.
- R10: A register write takes effect for accesses sampled from the next edge on. An access sampled at the same edge as the write uses the old value.
- R11: On every valid response exactly one of `rsp_dram` and `rsp_fwd` is high, and `rsp_cache` is never high together with `rsp_fwd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_idx | input | 3 | Attribute register index |
| cfg_wdata | input | 8 | Attribute register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_code | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Routing result valid |
| rsp_dram | output | 1 | Main memory services the access |
| rsp_fwd | output | 1 | Access is forwarded to the bus |
| rsp_cache | output | 1 | Access may be cached |

## Verification
An attribute register update and an access that reads that same register can fall in the same cycle. The bench provokes this by writing the register that covers the region being accessed in the same cycle as the access. It expects the routing from the old attribute first. On the next access to that region it expects the routing from the new attribute. The reference model keeps its register copy separate and updates it only after it has computed the expected result for that cycle. This catches a design that lets the new value bypass into the decode too early.

// File: rtl/umr_pkg.sv
package umr_pkg;

    localparam int ATTR_W = 4;
    localparam int REG_W  = 2 * ATTR_W;

    typedef struct packed {
        logic rsvd;
        logic cache_en;
        logic wr_en;
        logic rd_en;
    } attr_t;

    typedef struct packed {
        logic dram;
        logic fwd;
        logic cache;
    } route_t;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_RO,
        MODE_WO,
        MODE_RW
    } mode_e;

    function automatic mode_e attr_mode(input attr_t a);
        mode_e m;
        unique case ({a.wr_en, a.rd_en})
            2'b00:   m = MODE_OFF;
            2'b01:   m = MODE_RO;
            2'b10:   m = MODE_WO;
            default: m = MODE_RW;
        endcase
        return m;
    endfunction

    function automatic route_t route_access(input logic in_win, input attr_t a,
                                            input logic is_wr, input logic is_code);
        route_t r;
        r = '{dram: 1'b0, fwd: 1'b1, cache: 1'b0};
        if (!in_win) begin
            r = '{dram: 1'b1, fwd: 1'b0, cache: 1'b1};
        end else begin
            unique case (attr_mode(a))
                MODE_OFF: r = '{dram: 1'b0, fwd: 1'b1, cache: 1'b0};
                MODE_RO: begin
                    if (!is_wr) r = '{dram: 1'b1, fwd: 1'b0, cache: a.cache_en & is_code};
                end
                MODE_WO: begin
                    if (is_wr) r = '{dram: 1'b1, fwd: 1'b0, cache: 1'b0};
                end
                MODE_RW: r = '{dram: 1'b1, fwd: 1'b0, cache: a.cache_en};
                default: r = '{dram: 1'b0, fwd: 1'b1, cache: 1'b0};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/umr_addr_decode.sv
module umr_addr_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned REGION_LG = 14,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hC0000,
    localparam int unsigned NUM_REGIONS = 2 * NUM_REGS,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              in_win,
    output logic [IDX_W-1:0]  region
);
    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NUM_REGIONS) << REGION_LG;
    localparam logic [ADDR_W-1:0] WIN_LAST  = WIN_BASE + WIN_BYTES - ADDR_W'(1);

    always_comb begin
        in_win = (acc_addr >= WIN_BASE) && (acc_addr <= WIN_LAST);
        region = acc_addr[REGION_LG +: IDX_W];
    end
endmodule

// File: rtl/umr_attr_bank.sv
module umr_attr_bank
    import umr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned NUM_REGIONS = 2 * NUM_REGS,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS),
    localparam int unsigned CFG_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0] region,
    output attr_t            attr
);
    logic [REG_W-1:0] bank [NUM_REGS];
    logic [REG_W-1:0] sel;

    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(NUM_REGS); k++) begin
            if (rst) begin
                bank[k] <= '0;
            end else if (cfg_we && (cfg_idx == CFG_W'(k))) begin
                bank[k] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        sel  = bank[region[IDX_W-1:1]];
        attr = region[0] ? attr_t'(sel[REG_W-1:ATTR_W]) : attr_t'(sel[ATTR_W-1:0]);
    end
endmodule

// File: rtl/umr_resp_reg.sv
module umr_resp_reg
    import umr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc_valid,
    input  route_t route_in,
    output logic   rsp_valid,
    output route_t route_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            route_q   <= '0;
        end else begin
            rsp_valid <= acc_valid;
            route_q   <= acc_valid ? route_in : '0;
        end
    end
endmodule

// File: rtl/upper_mem_router.sv
module upper_mem_router
    import umr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned REGION_LG = 14,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hC0000,
    localparam int unsigned NUM_REGIONS = 2 * NUM_REGS,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS),
    localparam int unsigned CFG_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_code,
    output logic              rsp_valid,
    output logic              rsp_dram,
    output logic              rsp_fwd,
    output logic              rsp_cache
);
    logic             in_win;
    logic [IDX_W-1:0] region;
    attr_t            attr;
    route_t           route_now;
    route_t           route_q;

    umr_addr_decode #(
        .ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .NUM_REGS(NUM_REGS), .WIN_BASE(WIN_BASE)
    ) u_dec (
        .acc_addr(acc_addr), .in_win(in_win), .region(region)
    );

    umr_attr_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .region(region), .attr(attr)
    );

    always_comb route_now = route_access(in_win, attr, acc_write, acc_code);

    umr_resp_reg u_resp (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .route_in(route_now),
        .rsp_valid(rsp_valid), .route_q(route_q)
    );

    assign rsp_dram  = route_q.dram;
    assign rsp_fwd   = route_q.fwd;
    assign rsp_cache = route_q.cache;
endmodule

// File: rtl/umr_checker.sv
module umr_checker #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned REGION_LG = 14,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hC0000
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rsp_valid,
    input logic              rsp_dram,
    input logic              rsp_fwd,
    input logic              rsp_cache
);
    localparam logic [ADDR_W-1:0] WIN_LAST =
        WIN_BASE + ((ADDR_W'(2 * NUM_REGS)) << REGION_LG) - ADDR_W'(1);

    logic outside;
    assign outside = (acc_addr < WIN_BASE) || (acc_addr > WIN_LAST);

    // R11: one destination per response
    a_r11_one_route: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_dram, rsp_fwd}));

    // R11: bus-forwarded accesses are never cacheable
    a_r11_no_cache_fwd: assert property (@(posedge clk) disable iff (rst)
        rsp_fwd |-> !rsp_cache);

    // R9: quiet outputs without an access
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_dram || rsp_fwd || rsp_cache));

    // R9: one-cycle latency
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !rst) |=> rsp_valid);

    // R8: outside the window goes to memory, cacheable
    a_r8_outside_dram: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && outside) |=> (rsp_dram && rsp_cache));
endmodule

bind upper_mem_router umr_checker #(
    .ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .NUM_REGS(NUM_REGS), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_dram(rsp_dram), .rsp_fwd(rsp_fwd), .rsp_cache(rsp_cache)
);

// File: tb/upper_mem_router_tb.sv
module upper_mem_router_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic        acc_code;
    logic        rsp_valid, rsp_dram, rsp_fwd, rsp_cache;

    int checks = 0;
    int errors = 0;
    byte unsigned model [8];

    always #4 clk = ~clk;

    upper_mem_router u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_code(acc_code),
        .rsp_valid(rsp_valid), .rsp_dram(rsp_dram), .rsp_fwd(rsp_fwd), .rsp_cache(rsp_cache)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,dram,fwd,cache} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Behavioural expectation: returns {valid,dram,fwd,cache}
    task automatic expect_of(input logic [31:0] a, input bit w, input bit c,
                             output logic [3:0] e, output string tag);
        int nib;
        if (a < 32'hC0000 || a > 32'hFFFFF) begin
            e = 4'b1101; tag = "R8";
        end else begin
            nib = (int'(model[(a >> 15) & 7]) >> (((a >> 14) & 1) * 4)) & 15;
            tag = (nib >= 8) ? "R2 R3" : "R2";
            case (nib % 4)
                0: begin e = 4'b1010; tag = {tag, " R4"}; end
                1: begin
                    if (w) e = 4'b1010;
                    else   e = {3'b110, (((nib / 4) % 2) == 1) && c};
                    tag = {tag, " R5"};
                end
                2: begin e = w ? 4'b1100 : 4'b1010; tag = {tag, " R6"}; end
                default: begin e = {3'b110, ((nib / 4) % 2) == 1}; tag = {tag, " R7"}; end
            endcase
        end
    endtask

    // One cycle: drive, predict from old model, update model, sample after edge
    task automatic step(input bit we, input int idx, input int wd,
                        input bit v, input logic [31:0] a, input bit w, input bit c,
                        input string extra);
        logic [3:0] e;
        string tag;
        cfg_we = we; cfg_idx = 3'(idx); cfg_wdata = 8'(wd);
        acc_valid = v; acc_addr = a; acc_write = w; acc_code = c;
        if (v) expect_of(a, w, c, e, tag);
        else begin e = 4'b0000; tag = "R9"; end
        if (extra != "") tag = {tag, " ", extra};
        if (we) model[idx] = byte'(wd);
        @(posedge clk); #1;
        check(tag, {rsp_valid, rsp_dram, rsp_fwd, rsp_cache}, e);
        if (rsp_valid) begin
            checks++;
            if (!((rsp_dram ^ rsp_fwd) && !(rsp_fwd && rsp_cache))) begin
                errors++;
                $display("FAIL R11: dram %b fwd %b cache %b expected one route, no cache on fwd",
                         rsp_dram, rsp_fwd, rsp_cache);
            end
        end
    endtask

    task automatic sweep_window();
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 4; k++) begin
                step(0, 0, 0, 1, 32'hC0000 + r * 32'h4000 + 32'h123 * k,
                     (k % 2) == 1, k >= 2, "");
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        rst = 1'b1;
        cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
        acc_valid = 1; acc_addr = 32'hC0000; acc_write = 0; acc_code = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {rsp_valid, rsp_dram, rsp_fwd, rsp_cache}, 4'b0000);
        rst = 1'b0;

        // R1: reset state forwards the whole window
        step(0, 0, 0, 1, 32'hC4000, 0, 1, "R1");
        step(0, 0, 0, 1, 32'hFFFFF, 1, 0, "R1");
        step(0, 0, 0, 0, 32'hC0000, 0, 0, "R9 idle");

        // R8: outside the window
        step(0, 0, 0, 1, 32'h000BFFFF, 0, 0, "");
        step(0, 0, 0, 1, 32'h00100000, 1, 0, "");
        step(0, 0, 0, 1, 32'h00000000, 0, 1, "");

        // Region r gets nibble r: every encoding, reserved bit included (R2, R3)
        for (int k = 0; k < 8; k++) step(1, k, ((2 * k + 1) << 4) | (2 * k), 0, 0, 0, 0, "");
        sweep_window();

        // Reversed: region r gets nibble 15-r
        for (int k = 0; k < 8; k++)
            step(1, k, ((15 - (2 * k + 1)) << 4) | (15 - 2 * k), 0, 0, 0, 0, "");
        sweep_window();

        // R8 with registers loaded
        step(0, 0, 0, 1, 32'h000BFFFF, 1, 1, "");

        // R10: same-cycle write and access use the old attribute
        step(1, 0, 8'h00, 0, 0, 0, 0, "");
        step(1, 0, 8'h77, 1, 32'hC0010, 0, 0, "R10 old value");
        step(0, 0, 0, 1, 32'hC0010, 0, 0, "R10 new value");
        step(1, 0, 8'h00, 1, 32'hC4010, 1, 0, "R10 old value");
        step(0, 0, 0, 1, 32'hC4010, 1, 0, "R10 new value");

        // Shadow copy flow: write-only then read-only (R6, R5)
        step(1, 7, 8'h22, 0, 0, 0, 0, "");
        step(0, 0, 0, 1, 32'hFC000, 0, 0, "R6 shadow read");
        step(0, 0, 0, 1, 32'hFC000, 1, 0, "R6 shadow write");
        step(1, 7, 8'h55, 0, 0, 0, 0, "");
        step(0, 0, 0, 1, 32'hFC000, 0, 1, "R5 code read");
        step(0, 0, 0, 1, 32'hFC000, 0, 0, "R5 data read");
        step(0, 0, 0, 1, 32'hFC000, 1, 0, "R5 protected write");
        step(0, 0, 0, 0, 0, 0, 0, "R9 idle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule